// File: doc/BRIEF.md
# CAN Low-Power Entry and Wake-Up Controller

This block sits beside a CAN controller and decides when the controller may really enter one of its two low-power modes, Disable and Stop. The CPU raises a request for either mode; the block holds the request until the transmit and receive engines both report idle, then moves to the requested mode and raises a low-power acknowledge. The CPU polls that acknowledge to learn that the controller has settled. Dropping the request returns the block to normal operation.

While in Stop, the block can watch the bus receive line for new traffic. The receive line passes through a synchronizer, and a falling edge from recessive (1) to dominant (0) raises a sticky wake-up interrupt. This happens only if self wake-up was enabled at the moment Stop was entered and the wake-up interrupt is enabled. The CPU uses that interrupt to restart clocks. It clears the interrupt by writing a one to the clear input.

Top module: `canlp_ctrl`

## Requirements
- R1: After reset, `lp_ack` is 0, `wake_irq` is 0, `lp_mode` is 0 (normal), and both configuration bits are 0.
- R2: `lp_ack` is 1 exactly when `lp_mode` is Disable (1) or Stop (2). It rises on the first clock edge at which a request is sampled with both busy inputs low.
- R3: While `tx_busy` or `rx_busy` is high, no low-power mode is entered and `lp_ack` stays 0.
- R4: When the request for the current mode is removed, the block returns to normal mode (0). `lp_ack` drops on the next clock edge.
- R5: Self wake-up is armed only from the enable value held when Stop is entered. If the enable was 0 at entry, a bus falling edge during that Stop raises no interrupt.
- R6: In armed Stop with the interrupt enabled, a 1-to-0 transition on `bus_rx` sets `wake_irq` after SYNC_STAGES+1 clock edges.
- R7: A bus falling edge in normal mode or in Disable mode never sets `wake_irq`.
- R8: With the wake-up interrupt enable at 0, a falling edge in armed Stop does not set `wake_irq`.
- R9: A configuration write while in Stop leaves the self wake-up enable unchanged. The interrupt enable is still written.
- R10: `wake_irq` stays set until a cycle with `irq_clr` high, which clears it on the next edge.
- R11: If both requests are present when the block is idle and in normal mode, Disable (1) is entered rather than Stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_disable | input | 1 | CPU request for Disable mode |
| req_stop | input | 1 | CPU request for Stop mode |
| tx_busy | input | 1 | Transmit engine has a frame in progress |
| rx_busy | input | 1 | Receive engine has a frame in progress |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_selfwake | input | 1 | Write data: self wake-up enable |
| cfg_irq_en | input | 1 | Write data: wake-up interrupt enable |
| irq_clr | input | 1 | Write-1-to-clear for the wake-up interrupt |
| bus_rx | input | 1 | Asynchronous bus receive line, 1 = recessive |
| lp_ack | output | 1 | Low-power acknowledge |
| wake_irq | output | 1 | Sticky wake-up interrupt |
| lp_mode | output | 2 | Current mode: 0 normal, 1 Disable, 2 Stop |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2. This moves the wake-up latency to four edges, so the bench's check one edge early and its check exactly on time confirm that the delay follows the parameter and is not fixed. The rest of the sequence drives busy stalls, an enable write made during Stop, and arming with the enable cleared at entry. With the deeper synchronizer it also shows that a falling edge is registered only once the full chain has flushed.

// File: rtl/canlp_pkg.sv
package canlp_pkg;
  typedef enum logic [1:0] {
    LP_NORMAL  = 2'd0,
    LP_DISABLE = 2'd1,
    LP_STOP    = 2'd2
  } lp_mode_e;
endpackage

// File: rtl/canlp_sync.sv
module canlp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q,
  output logic q_prev
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b1;
    else     chain[0] <= d;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b1;
        else     chain[i] <= chain[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) q_prev <= 1'b1;
    else     q_prev <= chain[STAGES-1];
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/canlp_mode_fsm.sv
module canlp_mode_fsm
  import canlp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     req_disable,
  input  logic     req_stop,
  input  logic     busy,
  output lp_mode_e mode,
  output logic     lp_ack,
  output logic     stop_entry
);
  lp_mode_e nxt;

  always_comb begin
    nxt = mode;
    unique case (mode)
      LP_NORMAL: begin
        if (req_disable && !busy)   nxt = LP_DISABLE;
        else if (req_stop && !busy) nxt = LP_STOP;
      end
      LP_DISABLE: if (!req_disable) nxt = LP_NORMAL;
      LP_STOP:    if (!req_stop)    nxt = LP_NORMAL;
      default:    nxt = LP_NORMAL;
    endcase
  end

  assign stop_entry = (mode == LP_NORMAL) && (nxt == LP_STOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= LP_NORMAL;
      lp_ack <= 1'b0;
    end else begin
      mode   <= nxt;
      lp_ack <= (nxt != LP_NORMAL);
    end
  end
endmodule

// File: rtl/canlp_wake.sv
module canlp_wake
  import canlp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cfg_we,
  input  logic     cfg_selfwake,
  input  logic     cfg_irq_en,
  input  logic     irq_clr,
  input  lp_mode_e mode,
  input  logic     stop_entry,
  input  logic     rx_now,
  input  logic     rx_prev,
  output logic     wake_irq
);
  logic selfwake_q;
  logic irq_en_q;
  logic armed_q;
  logic fall_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      selfwake_q <= 1'b0;
      irq_en_q   <= 1'b0;
    end else if (cfg_we) begin
      irq_en_q <= cfg_irq_en;
      if (mode != LP_STOP) selfwake_q <= cfg_selfwake;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  armed_q <= 1'b0;
    else if (stop_entry)      armed_q <= selfwake_q;
    else if (mode != LP_STOP) armed_q <= 1'b0;
  end

  assign fall_seen = (mode == LP_STOP) && armed_q && rx_prev && !rx_now;

  always_ff @(posedge clk) begin
    if (rst)                        wake_irq <= 1'b0;
    else if (fall_seen && irq_en_q) wake_irq <= 1'b1;
    else if (irq_clr)               wake_irq <= 1'b0;
  end
endmodule

// File: rtl/canlp_ctrl.sv
module canlp_ctrl
  import canlp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_disable,
  input  logic       req_stop,
  input  logic       tx_busy,
  input  logic       rx_busy,
  input  logic       cfg_we,
  input  logic       cfg_selfwake,
  input  logic       cfg_irq_en,
  input  logic       irq_clr,
  input  logic       bus_rx,
  output logic       lp_ack,
  output logic       wake_irq,
  output logic [1:0] lp_mode
);
  lp_mode_e mode;
  logic     stop_entry;
  logic     rx_now;
  logic     rx_prev;

  canlp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d      (bus_rx),
    .q      (rx_now),
    .q_prev (rx_prev)
  );

  canlp_mode_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req_disable (req_disable),
    .req_stop    (req_stop),
    .busy        (tx_busy | rx_busy),
    .mode        (mode),
    .lp_ack      (lp_ack),
    .stop_entry  (stop_entry)
  );

  canlp_wake u_wake (
    .clk          (clk),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .cfg_selfwake (cfg_selfwake),
    .cfg_irq_en   (cfg_irq_en),
    .irq_clr      (irq_clr),
    .mode         (mode),
    .stop_entry   (stop_entry),
    .rx_now       (rx_now),
    .rx_prev      (rx_prev),
    .wake_irq     (wake_irq)
  );

  assign lp_mode = mode;
endmodule

// File: rtl/canlp_ctrl_chk.sv
module canlp_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_disable,
  input logic       req_stop,
  input logic       tx_busy,
  input logic       rx_busy,
  input logic       irq_clr,
  input logic       lp_ack,
  input logic       wake_irq,
  input logic [1:0] lp_mode
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!lp_ack && !wake_irq && lp_mode == 2'd0));

  assert_ack_matches_mode_R2: assert property (@(posedge clk) disable iff (rst)
    lp_ack == (lp_mode != 2'd0));

  assert_no_entry_when_busy_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(lp_ack) |-> $past(!tx_busy && !rx_busy));

  assert_release_drops_ack_R4: assert property (@(posedge clk) disable iff (rst)
    (!req_disable && !req_stop) |=> !lp_ack);

  assert_wake_only_from_stop_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_irq) |-> $past(lp_mode) == 2'd2);

  assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (wake_irq && !irq_clr) |=> wake_irq);
endmodule

bind canlp_ctrl canlp_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_disable (req_disable),
  .req_stop    (req_stop),
  .tx_busy     (tx_busy),
  .rx_busy     (rx_busy),
  .irq_clr     (irq_clr),
  .lp_ack      (lp_ack),
  .wake_irq    (wake_irq),
  .lp_mode     (lp_mode)
);

// File: tb/canlp_ctrl_bench.sv
`timescale 1ns/1ps
module canlp_ctrl_bench;
  localparam int SYNC = 3;
  localparam int LAT  = SYNC + 1;

  typedef struct {
    logic       ack;
    logic       irq;
    logic [1:0] mode;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_disable = 0, req_stop = 0, tx_busy = 0, rx_busy = 0;
  logic cfg_we = 0, cfg_selfwake = 0, cfg_irq_en = 0, irq_clr = 0, bus_rx = 1;
  logic lp_ack, wake_irq;
  logic [1:0] lp_mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t q[$];

  always #4 clk = ~clk;

  canlp_ctrl #(.SYNC_STAGES(SYNC)) u_canlp_ctrl (
    .clk(clk), .rst(rst), .req_disable(req_disable), .req_stop(req_stop),
    .tx_busy(tx_busy), .rx_busy(rx_busy), .cfg_we(cfg_we),
    .cfg_selfwake(cfg_selfwake), .cfg_irq_en(cfg_irq_en), .irq_clr(irq_clr),
    .bus_rx(bus_rx), .lp_ack(lp_ack), .wake_irq(wake_irq), .lp_mode(lp_mode)
  );

  // monitor: compare queued expectations at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (lp_ack !== e.ack || wake_irq !== e.irq || lp_mode !== e.mode) begin
        errors++;
        $display("FAIL %s: ack=%b irq=%b mode=%0d expected ack=%b irq=%b mode=%0d",
                 e.tag, lp_ack, wake_irq, lp_mode, e.ack, e.irq, e.mode);
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expect_out(input logic a, input logic i, input logic [1:0] m, input string tag);
    exp_t e;
    e.ack = a; e.irq = i; e.mode = m; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic write_cfg(input logic sw, input logic ie);
    cfg_we = 1; cfg_selfwake = sw; cfg_irq_en = ie;
    step(1);
    cfg_we = 0;
  endtask

  task automatic clear_irq();
    irq_clr = 1; step(1); irq_clr = 0;
  endtask

  task automatic bus_pulse();
    bus_rx = 0; step(LAT);
    bus_rx = 1; step(LAT);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 0;
    expect_out(0, 0, 2'd0, "R1 reset state");
    step(1);

    write_cfg(1, 1);
    // R3: stall on busy
    tx_busy = 1; req_stop = 1; step(3);
    expect_out(0, 0, 2'd0, "R3 tx busy holds entry");
    tx_busy = 0; rx_busy = 1; step(2);
    expect_out(0, 0, 2'd0, "R3 rx busy holds entry");
    rx_busy = 0; step(1);
    expect_out(1, 0, 2'd2, "R2 stop entered after idle");

    // R6: wake latency
    bus_rx = 0; step(SYNC);
    expect_out(1, 0, 2'd2, "R6 no irq before latency");
    step(1);
    expect_out(1, 1, 2'd2, "R6 irq at latency");
    bus_rx = 1; step(5);
    expect_out(1, 1, 2'd2, "R10 irq sticky");
    clear_irq();
    expect_out(1, 0, 2'd2, "R10 irq cleared by W1C");
    step(LAT);

    // R9: write in stop ignored for self-wake bit
    write_cfg(0, 1);
    req_stop = 0; step(1);
    expect_out(0, 0, 2'd0, "R4 ack drops after release");
    req_stop = 1; step(1);
    expect_out(1, 0, 2'd2, "R2 stop re-entered");
    bus_rx = 0; step(LAT);
    expect_out(1, 1, 2'd2, "R9 self-wake kept despite write in stop");
    bus_rx = 1; step(LAT);
    clear_irq();

    // R5: disarmed at entry
    req_stop = 0; step(1);
    write_cfg(0, 1);
    req_stop = 1; step(1);
    bus_pulse();
    expect_out(1, 0, 2'd2, "R5 no wake when disabled at entry");

    // R7: normal mode and disable mode
    req_stop = 0; step(1);
    write_cfg(1, 1);
    bus_pulse();
    expect_out(0, 0, 2'd0, "R7 no wake in normal mode");
    req_disable = 1; step(1);
    expect_out(1, 0, 2'd1, "R2 disable entered");
    bus_pulse();
    expect_out(1, 0, 2'd1, "R7 no wake in disable mode");
    req_disable = 0; step(1);
    expect_out(0, 0, 2'd0, "R4 leave disable");

    // R11: both requests
    req_disable = 1; req_stop = 1; step(1);
    expect_out(1, 0, 2'd1, "R11 disable wins");
    bus_pulse();
    expect_out(1, 0, 2'd1, "R11 no wake in disable");
    req_disable = 0; req_stop = 0; step(1);

    // R8: interrupt enable off
    write_cfg(1, 0);
    req_stop = 1; step(1);
    bus_pulse();
    expect_out(1, 0, 2'd2, "R8 no irq when interrupt disabled");
    req_stop = 0; step(1);
    expect_out(0, 0, 2'd0, "R4 final release");
    step(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule